// File: doc/BRIEF.md
# Windowed Limit Fault Status

This block watches three measurements against programmable limits: a remote-diode temperature (zone 1), an on-die temperature (zone 2) and a fan tachometer period count. Each temperature has a window made of a low limit and a high limit. The fan count has a single minimum-speed count. The limits arrive on input ports, and the values held in limit registers elsewhere in the chip drive them.

Fault conditions are gathered into two byte-wide interrupt status registers. Each status bit latches when its fault is seen and holds until software reads its register. On the edge that ends the read, a bit clears only if its fault has gone away.

A third byte reports the present comparison results and the converter busy flag without any latching. Software reads all three bytes through a small read port. An interrupt line is raised while any status bit is set.

Top module: `limit_fault_status`

## Requirements
- R1: Temperatures and limits are signed two's complement values. A low fault exists when the measurement is less than or equal to its low limit. A high fault exists only when the measurement is strictly greater than its high limit.
- R2: Address 1 returns interrupt status 1. Bit 4 is the zone 1 (remote) window fault, bit 5 is the zone 2 (local) window fault, and bit 7 is the summary of status 2. Bits 6 and 3:0 read 0, and the value after reset is 00h.
- R3: Address 2 returns interrupt status 2. Bit 6 is the sensor error and bit 2 is the fan-slow fault, which exists when the tach count is strictly greater than the minimum count. All other bits read 0, and the value after reset is 00h.
- R4: An asserted remote-diode open/short flag sets the zone 1 bit, even when the remote temperature lies inside its window.
- R5: Bit 7 of status 1 reads 1 whenever any bit of status 2 is set, and reads 0 otherwise.
- R6: A status bit that has been set stays set until its own register is read, even if the fault ends first. A read of any other address does not disturb it.
- R7: A read takes effect on the clock edge at the end of the read-strobe cycle. At that edge each bit of the register being read takes the value of its fault condition sampled there. A fault still present, or a fault that first appears in the read cycle, leaves the bit at 1. The data returned during the read is the value held before that edge.
- R8: Address 0 returns the live alert byte, which is not latched. Bit 2 is diode open/short, bit 3 is remote low, bit 4 is remote high, bit 5 is local low, bit 6 is local high, bit 7 is converter busy, and bits 1:0 are 0.
- R9: The interrupt output is 1 exactly when at least one bit of either status register is set.
- R10: Address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| remote_temp | input | TEMP_W | Zone 1 measured temperature, signed |
| remote_lo | input | TEMP_W | Zone 1 low limit, signed |
| remote_hi | input | TEMP_W | Zone 1 high limit, signed |
| local_temp | input | TEMP_W | Zone 2 measured temperature, signed |
| local_lo | input | TEMP_W | Zone 2 low limit, signed |
| local_hi | input | TEMP_W | Zone 2 high limit, signed |
| tach_count | input | TACH_W | Fan period count |
| tach_min | input | TACH_W | Largest acceptable period count |
| diode_fault | input | 1 | Remote diode open or shorted |
| sensor_err | input | 1 | Temperature sensor error |
| conv_busy | input | 1 | Converter busy |
| rd_addr | input | ADDR_W | Read address |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Read data, valid during the strobe cycle |
| irq | output | 1 | Any status bit set |

## Verification
The bench tests each window edge from both sides. A comparison with the wrong strictness, or an unsigned comparison, shows up as a stray or missing bit when a measurement equals a limit or when a negative reading is compared against a positive limit. It also sends one-cycle fault pulses and then reads twice. A design that clears on every read, or never clears at all, gives the wrong second value. A fault that is held through the read, a fault that first appears in the read cycle, and a read of the other register all check the clear-on-read edge. If the clear came before the set, or if the clear reached into the wrong register, the bit would vanish.

// File: rtl/limit_fault_status.sv
module limit_fault_status #(
  parameter int TEMP_W = 8,
  parameter int TACH_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] remote_temp,
  input  logic signed [TEMP_W-1:0] remote_lo,
  input  logic signed [TEMP_W-1:0] remote_hi,
  input  logic signed [TEMP_W-1:0] local_temp,
  input  logic signed [TEMP_W-1:0] local_lo,
  input  logic signed [TEMP_W-1:0] local_hi,
  input  logic        [TACH_W-1:0] tach_count,
  input  logic        [TACH_W-1:0] tach_min,
  input  logic                     diode_fault,
  input  logic                     sensor_err,
  input  logic                     conv_busy,
  input  logic        [ADDR_W-1:0] rd_addr,
  input  logic                     rd_en,
  output logic        [7:0]        rd_data,
  output logic                     irq
);
  localparam logic [ADDR_W-1:0] A_ALERT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_INT1  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_INT2  = ADDR_W'(2);

  wire r_low  = remote_temp <= remote_lo;
  wire r_high = remote_temp >  remote_hi;
  wire l_low  = local_temp  <= local_lo;
  wire l_high = local_temp  >  local_hi;

  wire z1_fault  = r_low | r_high | diode_fault;
  wire z2_fault  = l_low | l_high;
  wire fan_fault = tach_count > tach_min;

  wire rd1 = rd_en && (rd_addr == A_INT1);
  wire rd2 = rd_en && (rd_addr == A_INT2);

  logic z1_q, z2_q, fan_q, serr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z1_q   <= 1'b0;
      z2_q   <= 1'b0;
      fan_q  <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      z1_q   <= rd1 ? z1_fault   : (z1_q   | z1_fault);
      z2_q   <= rd1 ? z2_fault   : (z2_q   | z2_fault);
      fan_q  <= rd2 ? fan_fault  : (fan_q  | fan_fault);
      serr_q <= rd2 ? sensor_err : (serr_q | sensor_err);
    end
  end

  wire       summary = fan_q | serr_q;
  wire [7:0] int1    = {summary, 1'b0, z2_q, z1_q, 4'b0000};
  wire [7:0] int2    = {1'b0, serr_q, 3'b000, fan_q, 2'b00};
  wire [7:0] alert   = {conv_busy, l_high, l_low, r_high, r_low, diode_fault, 2'b00};

  always_comb begin
    case (rd_addr)
      A_ALERT: rd_data = alert;
      A_INT1:  rd_data = int1;
      A_INT2:  rd_data = int2;
      default: rd_data = 8'h00;
    endcase
  end

  assign irq = z1_q | z2_q | fan_q | serr_q;
endmodule

module limit_fault_status_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              irq,
  input logic              z1_q,
  input logic              fan_q,
  input logic              serr_q,
  input logic              z1_fault
);
  wire rd1 = rd_en && (rd_addr == ADDR_W'(1));

  // R6
  z1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z1_q && !rd1 |=> z1_q);

  // R7
  z1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 && !z1_fault |=> !z1_q);

  // R7
  z1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 && z1_fault |=> z1_q);

  // R5
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 |-> rd_data[7] == (fan_q | serr_q));

  // R2
  int1_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 |-> rd_data[3:0] == 4'h0 && !rd_data[6]);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> !z1_q && !fan_q && !serr_q);
endmodule

bind limit_fault_status limit_fault_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_en(rd_en),
  .rd_data(rd_data), .irq(irq), .z1_q(z1_q), .fan_q(fan_q),
  .serr_q(serr_q), .z1_fault(z1_fault)
);

// File: tb/test_limit_fault_status.sv
module test_limit_fault_status;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [7:0] remote_temp, remote_lo, remote_hi;
  logic signed [7:0] local_temp, local_lo, local_hi;
  logic [15:0] tach_count, tach_min;
  logic diode_fault, sensor_err, conv_busy, rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  limit_fault_status i_limit_fault_status (
    .clk(clk), .rst_n(rst_n),
    .remote_temp(remote_temp), .remote_lo(remote_lo), .remote_hi(remote_hi),
    .local_temp(local_temp), .local_lo(local_lo), .local_hi(local_hi),
    .tach_count(tach_count), .tach_min(tach_min),
    .diode_fault(diode_fault), .sensor_err(sensor_err), .conv_busy(conv_busy),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a; rd_en = 1'b0;
    #1 d = rd_data;
  endtask

  task automatic quiet;
    @(negedge clk);
    remote_temp = 8'sd20; remote_lo = 8'sd10; remote_hi = 8'sd50;
    local_temp = 8'sd25; local_lo = 8'sd0; local_hi = 8'sd80;
    tach_count = 16'd500; tach_min = 16'd1000;
    diode_fault = 0; sensor_err = 0; conv_busy = 0;
  endtask

  task automatic drain;
    logic [7:0] d;
    rd(2'd1, d); rd(2'd2, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd1, d); chk("R2 reset", d, 8'h00);
    rd(2'd2, d); chk("R3 reset", d, 8'h00);
    chk("R9 reset irq", {7'd0, irq}, 8'h00);
    rd(2'd3, d); chk("R10 addr3", d, 8'h00);
  endtask

  task automatic t_window;
    logic [7:0] d;
    quiet(); remote_temp = 8'sd10;
    #1 peek(2'd0, d); chk("R1/R8 remote low equal", d, 8'h08);
    remote_temp = 8'sd11; #1 chk("R1 remote above low", rd_data, 8'h00);
    remote_temp = 8'sd50; #1 chk("R1 remote equal high", rd_data, 8'h00);
    remote_temp = 8'sd51; #1 chk("R1/R8 remote over high", rd_data, 8'h10);
    remote_temp = -8'sd1; remote_lo = -8'sd5; #1 chk("R1 signed negative in window", rd_data, 8'h00);
    remote_temp = -8'sd5; #1 chk("R1 signed low equal", rd_data, 8'h08);
    remote_temp = 8'sd20; remote_lo = 8'sd10;
    local_temp = 8'sd0; #1 chk("R8 local low", rd_data, 8'h20);
    local_temp = 8'sd81; conv_busy = 1; #1 chk("R8 local high busy", rd_data, 8'hC0);
    quiet(); drain();
  endtask

  task automatic t_latch;
    logic [7:0] d;
    quiet(); remote_temp = 8'sd60;
    quiet();
    chk("R9 irq after pulse", {7'd0, irq}, 8'h01);
    rd(2'd2, d); chk("R6 other read", d, 8'h00);
    rd(2'd1, d); chk("R6 latched zone1", d, 8'h10);
    rd(2'd1, d); chk("R7 cleared", d, 8'h00);
    chk("R9 irq clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_persist;
    logic [7:0] d;
    quiet(); local_temp = -8'sd3;
    rd(2'd1, d); chk("R7 first read zone2", d, 8'h20);
    rd(2'd1, d); chk("R7 still present", d, 8'h20);
    quiet();
    rd(2'd1, d); chk("R7 read after end", d, 8'h20);
    rd(2'd1, d); chk("R7 then cleared", d, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    quiet();
    @(negedge clk);
    rd_addr = 2'd1; rd_en = 1'b1; remote_temp = 8'sd70;
    #1 d = rd_data; chk("R7 old value in read cycle", d, 8'h00);
    @(negedge clk);
    rd_en = 1'b0; remote_temp = 8'sd20;
    rd(2'd1, d); chk("R7 fault in read cycle kept", d, 8'h10);
    rd(2'd1, d); chk("R7 cleared later", d, 8'h00);
  endtask

  task automatic t_diode;
    logic [7:0] d;
    quiet(); diode_fault = 1;
    #1 peek(2'd0, d); chk("R8 open bit", d, 8'h04);
    quiet();
    rd(2'd1, d); chk("R4 diode sets zone1", d, 8'h10);
    drain();
  endtask

  task automatic t_int2;
    logic [7:0] d;
    quiet(); sensor_err = 1;
    quiet();
    rd(2'd1, d); chk("R5 summary", d, 8'h80);
    rd(2'd2, d); chk("R3 sensor error", d, 8'h40);
    rd(2'd1, d); chk("R5 summary clears", d, 8'h00);
    quiet(); tach_count = 16'd1000;
    quiet();
    rd(2'd2, d); chk("R3 tach equal min", d, 8'h00);
    quiet(); tach_count = 16'd1001; remote_temp = 8'sd99; local_temp = 8'sd99;
    quiet();
    rd(2'd1, d); chk("R2/R5 all bits", d, 8'hB0);
    rd(2'd2, d); chk("R3 fan slow", d, 8'h04);
    rd(2'd2, d); chk("R7 int2 cleared", d, 8'h00);
    rd(2'd1, d); chk("R2 cleared", d, 8'h00);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual 00 expected 01");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rd_en = 0; rd_addr = 0;
    remote_temp = 8'sd20; remote_lo = 8'sd10; remote_hi = 8'sd50;
    local_temp = 8'sd25; local_lo = 8'sd0; local_hi = 8'sd80;
    tach_count = 16'd500; tach_min = 16'd1000;
    diode_fault = 0; sensor_err = 0; conv_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_window();
    t_latch();
    t_persist();
    t_same_cycle();
    t_diode();
    t_int2();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule